// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block produces the 8-bit data-memory address for each instruction of a small word-oriented DSP. It also owns the two 16-bit auxiliary registers and the one-bit pointer that selects between them. Each cycle the sequencer presents the low byte of the instruction, the current data-page bit and an operation kind. The block then drives the address and a memory-enable strobe combinationally, from the register values held before the cycle. At the end of the cycle it applies any post-increment, post-decrement, pointer reload or register load.

Bit 7 of the instruction byte selects the mode. In direct mode the address is the page bit followed by seven instruction bits. In indirect mode it is the low byte of the auxiliary register that the pointer selects, and bits 5, 4, 3 and 0 of the byte control the post-modification. The operation kind adapts these rules to several cases: loads into an auxiliary register, status-register stores and loads, modify-only instructions and immediate register loads.

Top module: `aux_addr_gen`

## Requirements
- R1: After a synchronous reset both auxiliary registers read 0x0000 and the pointer reads 0.
- R2: For kinds 0 (access), 1 (register load from memory) and 3 (status load), an instruction byte with bit 7 at 0 gives `mem_addr` = {page_bit, instr_lo[6:0]}.
- R3: For kinds 0 to 3 with bit 7 set, `mem_addr` equals bits 7:0 of the register selected by the pointer, as it stood before the cycle.
- R4: With bit 7 set and kind 0 to 4, bit 5 adds one and bit 4 subtracts one from bits 8:0 of the selected register, modulo 512. Bits 15:9 are kept. When both bits are set the value does not change.
- R5: With bit 7 set and kind 0, 1 or 4, the pointer takes instr_lo[0] at the clock edge when bit 3 is 0. The pointer is unchanged when bit 3 is 1.
- R6: Kind 1 writes ld_data (16 bits) into the register named by ld_sel. The post-modify is skipped when ld_sel equals the pointer. Otherwise it still applies to the pointer-selected register. The pointer follows R5.
- R7: Kind 2 (status store) in direct mode addresses 0x80 | instr_lo[6:0] whatever the page bit. In indirect mode it post-modifies per R4 but never changes the pointer.
- R8: Kind 3 (status load) never changes the pointer, whatever bit 3 holds. It still post-modifies per R4.
- R9: Kind 4 (modify only) keeps mem_en low. With bit 7 set it applies R4 and R5. With bit 7 clear it changes no state.
- R10: Kind 5 (immediate load) writes {8'h00, instr_lo} into the register named by ld_sel, keeps mem_en low and leaves the other register and the pointer unchanged.
- R11: mem_en is high exactly when op_valid is high and the kind is 0 to 3. With op_valid low, or with kind 6 or 7, no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_kind | input | 3 | 0 access, 1 register load, 2 status store, 3 status load, 4 modify only, 5 immediate load, 6/7 none |
| instr_lo | input | 8 | Low byte of the instruction |
| page_bit | input | 1 | Current data-page bit |
| ld_sel | input | 1 | Register targeted by kinds 1 and 5 |
| ld_data | input | 16 | Word loaded by kind 1 |
| mem_addr | output | 8 | Data-memory address |
| mem_en | output | 1 | Memory access this cycle |
| ar0_q | output | 16 | Auxiliary register 0 |
| ar1_q | output | 16 | Auxiliary register 1 |
| arp_q | output | 1 | Auxiliary register pointer |

## Verification
Directed sequences come first. Register values are placed at the 0x1FF/0x000 boundary so that a wrong modulus or a carry into bit 9 shows up in the upper bits. Increment, decrement and the both-set case are then applied to these values. Register loads are issued with the target equal to the pointer and then different from it, which separates the suppressed modify from a modify that wrongly hits the other register. Status stores use page bit 0 and status loads set bit 3 to 0, so that any leak of the page bit or of a pointer reload is visible. A long stream of random kinds and bytes follows, and a behavioural model checks the address and the register state on every cycle.

// File: rtl/aux_addr_pkg.sv
package aux_addr_pkg;

    localparam int LOW_W = 8;

    typedef enum logic [2:0] {
        OP_ACCESS   = 3'd0,
        OP_LOAD_AR  = 3'd1,
        OP_STAT_ST  = 3'd2,
        OP_STAT_LD  = 3'd3,
        OP_MODIFY   = 3'd4,
        OP_LOAD_IMM = 3'd5,
        OP_NONE6    = 3'd6,
        OP_NONE7    = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic             mem_en;
        logic             indirect;
        logic             fixed_page;
        logic             modify;
        logic             inc;
        logic             dec;
        logic             ptr_load;
        logic             ptr_val;
        logic             ar_load;
        logic             imm_load;
        logic [LOW_W-2:0] offset;
    } ctrl_t;

    function automatic logic touches_memory(op_kind_e k);
        return (k == OP_ACCESS) || (k == OP_LOAD_AR) ||
               (k == OP_STAT_ST) || (k == OP_STAT_LD);
    endfunction

    function automatic logic uses_indirect(op_kind_e k);
        return touches_memory(k) || (k == OP_MODIFY);
    endfunction

    function automatic logic holds_pointer(op_kind_e k);
        return (k == OP_STAT_ST) || (k == OP_STAT_LD);
    endfunction

endpackage

// File: rtl/aux_addr_decode.sv
module aux_addr_decode
    import aux_addr_pkg::*;
(
    input  logic             op_valid,
    input  logic [2:0]       op_kind,
    input  logic [LOW_W-1:0] instr_lo,
    input  logic             arp,
    input  logic             ld_sel,
    output ctrl_t            ctrl
);
    op_kind_e kind;
    logic     active_ind;
    logic     same_target;

    always_comb begin
        kind        = op_kind_e'(op_kind);
        active_ind  = op_valid && instr_lo[7] && uses_indirect(kind);
        same_target = (kind == OP_LOAD_AR) && (ld_sel == arp);

        ctrl            = '0;
        ctrl.mem_en     = op_valid && touches_memory(kind);
        ctrl.indirect   = instr_lo[7];
        ctrl.fixed_page = (kind == OP_STAT_ST);
        ctrl.inc        = instr_lo[5];
        ctrl.dec        = instr_lo[4];
        ctrl.modify     = active_ind && (instr_lo[5] || instr_lo[4]) && !same_target;
        ctrl.ptr_load   = active_ind && !instr_lo[3] && !holds_pointer(kind);
        ctrl.ptr_val    = instr_lo[0];
        ctrl.ar_load    = op_valid && (kind == OP_LOAD_AR);
        ctrl.imm_load   = op_valid && (kind == OP_LOAD_IMM);
        ctrl.offset     = instr_lo[LOW_W-2:0];
    end
endmodule

// File: rtl/aux_addr_mux.sv
module aux_addr_mux #(
    parameter int ADDR_W = 8
) (
    input  logic              indirect,
    input  logic              fixed_page,
    input  logic              page_bit,
    input  logic [ADDR_W-2:0] offset,
    input  logic [ADDR_W-1:0] sel_low,
    output logic [ADDR_W-1:0] addr
);
    logic page_eff;

    always_comb begin
        page_eff = fixed_page ? 1'b1 : page_bit;
        addr     = indirect ? sel_low : {page_eff, offset};
    end
endmodule

// File: rtl/aux_addr_step.sv
module aux_addr_step #(
    parameter int AR_W  = 16,
    parameter int MOD_W = 9
) (
    input  logic [AR_W-1:0] cur,
    input  logic            inc,
    input  logic            dec,
    output logic [AR_W-1:0] nxt
);
    localparam int PAD_W = MOD_W - 1;

    logic [MOD_W-1:0] low;

    always_comb begin
        low = cur[MOD_W-1:0] + {{PAD_W{1'b0}}, inc} - {{PAD_W{1'b0}}, dec};
        nxt = {cur[AR_W-1:MOD_W], low};
    end
endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen
    import aux_addr_pkg::*;
#(
    parameter int AR_W  = 16,
    parameter int MOD_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_kind,
    input  logic [LOW_W-1:0] instr_lo,
    input  logic             page_bit,
    input  logic             ld_sel,
    input  logic [AR_W-1:0]  ld_data,
    output logic [LOW_W-1:0] mem_addr,
    output logic             mem_en,
    output logic [AR_W-1:0]  ar0_q,
    output logic [AR_W-1:0]  ar1_q,
    output logic             arp_q
);
    localparam int NUM_AR = 2;
    localparam int ADDR_W = LOW_W;
    localparam int IMM_PAD = AR_W - LOW_W;

    ctrl_t           ctrl;
    logic [AR_W-1:0] ar_q    [NUM_AR];
    logic [AR_W-1:0] stepped [NUM_AR];
    logic [ADDR_W-1:0] sel_low;

    aux_addr_decode u_decode (
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .instr_lo (instr_lo),
        .arp      (arp_q),
        .ld_sel   (ld_sel),
        .ctrl     (ctrl)
    );

    always_comb sel_low = ar_q[arp_q][ADDR_W-1:0];

    aux_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .indirect   (ctrl.indirect),
        .fixed_page (ctrl.fixed_page),
        .page_bit   (page_bit),
        .offset     (ctrl.offset),
        .sel_low    (sel_low),
        .addr       (mem_addr)
    );

    assign mem_en = ctrl.mem_en;

    for (genvar g = 0; g < NUM_AR; g++) begin : g_ar
        aux_addr_step #(.AR_W(AR_W), .MOD_W(MOD_W)) u_step (
            .cur (ar_q[g]),
            .inc (ctrl.inc),
            .dec (ctrl.dec),
            .nxt (stepped[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                ar_q[g] <= '0;
            end else if (ctrl.ar_load && (ld_sel == 1'(g))) begin
                ar_q[g] <= ld_data;
            end else if (ctrl.imm_load && (ld_sel == 1'(g))) begin
                ar_q[g] <= {{IMM_PAD{1'b0}}, instr_lo};
            end else if (ctrl.modify && (arp_q == 1'(g))) begin
                ar_q[g] <= stepped[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) arp_q <= 1'b0;
        else if (ctrl.ptr_load) arp_q <= ctrl.ptr_val;
    end

    assign ar0_q = ar_q[0];
    assign ar1_q = ar_q[1];

    a_r3_indirect_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_en && instr_lo[7]) |-> (mem_addr == (arp_q ? ar1_q[ADDR_W-1:0] : ar0_q[ADDR_W-1:0])));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_kind inside {3'd0, 3'd2, 3'd3, 3'd4}))
        |=> (ar0_q[AR_W-1:MOD_W] == $past(ar0_q[AR_W-1:MOD_W]) &&
             ar1_q[AR_W-1:MOD_W] == $past(ar1_q[AR_W-1:MOD_W])));

    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (op_valid && instr_lo[3]) |=> (arp_q == $past(arp_q)));

    a_r7_page_one: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd2 && !instr_lo[7]) |-> mem_addr[ADDR_W-1]);

    a_r8_stat_ld_ptr: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd3) |=> $stable(arp_q));

    a_r9_no_mem: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd4) |-> !mem_en);

    a_r11_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !mem_en);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(ar0_q) && $stable(ar1_q) && $stable(arp_q)));

endmodule

// File: tb/test_aux_addr_gen.sv
module test_aux_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_kind;
    logic [7:0]  instr_lo;
    logic        page_bit;
    logic        ld_sel;
    logic [15:0] ld_data;
    logic [7:0]  mem_addr;
    logic        mem_en;
    logic [15:0] ar0_q;
    logic [15:0] ar1_q;
    logic        arp_q;

    int checks = 0;
    int failures = 0;
    int m_ar [2];
    int m_arp;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_addr_gen i_aux_addr_gen (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .instr_lo(instr_lo), .page_bit(page_bit), .ld_sel(ld_sel),
        .ld_data(ld_data), .mem_addr(mem_addr), .mem_en(mem_en),
        .ar0_q(ar0_q), .ar1_q(ar1_q), .arp_q(arp_q)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "ar0", int'(ar0_q), m_ar[0]);
        chk(req, "ar1", int'(ar1_q), m_ar[1]);
        chk(req, "arp", int'(arp_q), m_arp);
    endtask

    // One cycle: drive at falling edge, check address, then state after rising edge.
    task automatic run_op(input int valid, input int kind, input int instr, input int page,
                          input int sel, input int data, input string req);
        int ind, memk, exp_addr, b5, b4, b3, low, r;
        @(negedge clk);
        op_valid = 1'(valid);
        op_kind  = 3'(kind);
        instr_lo = 8'(instr);
        page_bit = 1'(page);
        ld_sel   = 1'(sel);
        ld_data  = 16'(data);
        #1;
        ind  = (instr >> 7) & 1;
        b5   = (instr >> 5) & 1;
        b4   = (instr >> 4) & 1;
        b3   = (instr >> 3) & 1;
        memk = (valid != 0 && kind <= 3) ? 1 : 0;
        chk(req, "mem_en", int'(mem_en), memk);
        if (memk != 0) begin
            if (ind != 0) exp_addr = m_ar[m_arp] & 255;
            else exp_addr = ((kind == 2) ? 128 : (page * 128)) | (instr & 127);
            chk(req, "mem_addr", int'(mem_addr), exp_addr);
        end
        if (valid != 0) begin
            if (ind != 0 && kind <= 4) begin
                r = m_arp;
                if ((b5 | b4) != 0 && !(kind == 1 && sel == m_arp)) begin
                    low = ((m_ar[r] & 511) + 512 + b5 - b4) % 512;
                    m_ar[r] = (m_ar[r] & 'hFE00) | low;
                end
                if (b3 == 0 && kind != 2 && kind != 3) m_arp = instr & 1;
            end
            if (kind == 1) m_ar[sel] = data & 'hFFFF;
            if (kind == 5) m_ar[sel] = instr & 255;
        end
        @(posedge clk);
        #1;
        chk_state(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 0; op_kind = 0; instr_lo = 0;
        page_bit = 0; ld_sel = 0; ld_data = 0;
        m_ar[0] = 0; m_ar[1] = 0; m_arp = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk_state("R1");

        // R10 immediate loads; mem_en low
        run_op(1, 5, 'h10, 0, 0, 0, "R10");
        run_op(1, 5, 'hF3, 1, 1, 'hBEEF, "R10");
        // R2/R6 direct register load, page 1
        run_op(1, 1, 'h22, 1, 0, 'hFE01, "R6");
        run_op(1, 0, 'h45, 0, 0, 0, "R2");
        run_op(1, 3, 'h7F, 1, 0, 0, "R2");
        // R3/R4/R5 indirect increment, pointer kept
        run_op(1, 0, 'hA8, 0, 0, 0, "R4");
        // wrap at 9 bits with upper bits preserved
        run_op(1, 1, 'h01, 0, 0, 'hA5FF, "R6");
        run_op(1, 0, 'hA8, 0, 0, 0, "R4");
        run_op(1, 0, 'h98, 0, 0, 0, "R4");
        run_op(1, 0, 'hB8, 0, 0, 0, "R4");
        // R5 pointer reload from bit 0
        run_op(1, 0, 'h81, 0, 0, 0, "R5");
        run_op(1, 0, 'h88, 0, 0, 0, "R5");
        // R6 load into the pointer-selected register: modify skipped
        run_op(1, 1, 'hA9, 0, 1, 'h1234, "R6");
        // R6 load into the other register: selected one still modified, pointer reloaded
        run_op(1, 1, 'hA0, 0, 0, 'h5678, "R6");
        // R7 status store direct ignores page bit; indirect never reloads pointer
        run_op(1, 2, 'h05, 0, 0, 0, "R7");
        run_op(1, 2, 'hA1, 0, 0, 0, "R7");
        // R8 status load with bit 3 clear
        run_op(1, 3, 'h91, 0, 0, 0, "R8");
        // R9 modify only
        run_op(1, 4, 'hA1, 0, 0, 0, "R9");
        run_op(1, 4, 'h3F, 1, 0, 0, "R9");
        // R11 idle and reserved kinds
        run_op(0, 0, 'hA0, 1, 1, 'hFFFF, "R11");
        run_op(1, 6, 'hB0, 1, 0, 'hFFFF, "R11");
        run_op(1, 7, 'h90, 0, 1, 'hFFFF, "R11");

        for (int n = 0; n < 400; n++) begin
            int v, k;
            v = ($urandom_range(0, 7) != 0) ? 1 : 0;
            k = $urandom_range(0, 7);
            run_op(v, k, $urandom_range(0, 255), $urandom_range(0, 1),
                   $urandom_range(0, 1), $urandom_range(0, 65535), "R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule